// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a two-part virtual address, a segment number and an offset within that segment, into a physical address. A small register table holds one descriptor for each segment. A descriptor has a base physical address, a segment length and a set of access rights. For each fetch, read or write request, the unit looks up the descriptor for the requested segment. It then checks the offset against the length and checks the kind of access against the rights. If both checks pass, it adds the base to the offset. If a check fails, it reports a fault with a cause code instead of an address.

A privileged configuration port writes descriptors one at a time. A separate combinational read port returns any stored descriptor. Together they let supervisor logic save the whole table when it switches context and load another table in its place. The response comes out of a register, one cycle after the request.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor has base 0, length 0 and no rights. Any request made before the table is loaded faults with cause 3 (no access).
- R2: Each request yields a response exactly one cycle later: `rsp_valid` equals the previous cycle's `req_valid`. In a cycle with no response, `rsp_fault`, `rsp_cause` and `rsp_paddr` are all zero.
- R3: A request that passes both checks returns `rsp_paddr` = base + offset, truncated to 24 bits (it wraps), with `rsp_fault` = 0 and `rsp_cause` = 0.
- R4: An offset greater than or equal to the segment length faults with cause 1 (bound). Legal offsets run from 0 to length-1. The length is 14 bits wide, so a length of 8192 admits every offset.
- R5: The rights field uses bit 0 for read, bit 1 for write and bit 2 for execute. The kind of access uses 0 for fetch (needs execute), 1 for read (needs read) and 2 for write (needs write). A missing right faults with cause 2 (permission). Kind 3 is reserved and always faults with cause 2.
- R6: A descriptor whose rights are 000 faults with cause 3, whatever the offset. When several checks fail, the cause reported is chosen in this order: no access first, then bound, then permission.
- R7: A faulting response has `rsp_fault` = 1 and `rsp_paddr` = 0.
- R8: When `cfg_we` is high at a clock edge, it stores base, length and rights into the entry selected by `cfg_seg`. From the next cycle on, the read port shows those values for that entry.
- R9: When a request and a descriptor write address the same segment in the same cycle, the request is translated with the contents from before the write. The next request sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write, 3 reserved |
| req_seg | input | 3 | Segment number of the virtual address |
| req_off | input | 13 | Offset within the segment |
| cfg_we | input | 1 | Privileged descriptor write strobe |
| cfg_seg | input | 3 | Entry to write |
| cfg_base | input | 24 | Base physical address to store |
| cfg_size | input | 14 | Segment length to store |
| cfg_rights | input | 3 | Rights to store: bit 0 read, bit 1 write, bit 2 execute |
| cfg_rd_seg | input | 3 | Entry to read back |
| cfg_rd_base | output | 24 | Stored base of the entry being read back |
| cfg_rd_size | output | 14 | Stored length of the entry being read back |
| cfg_rd_rights | output | 3 | Stored rights of the entry being read back |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 24 | Translated physical address, 0 on a fault |
| rsp_fault | output | 1 | Request was refused |
| rsp_cause | output | 2 | 0 ok, 1 bound, 2 permission, 3 no access |

## Verification
A descriptor write and a translation can happen in the same cycle for the same segment. The bench sets this up by holding a request on a segment while it rewrites that segment's base, length and rights on the same edge. It then checks that the response still carries the address and verdict of the old descriptor. The following request on that segment must carry the verdict of the new descriptor. The sweeps over segment, kind and boundary offsets also take the bench across each change of cause priority, at offsets of size-1, size and size+1.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        CAUSE_OK    = 2'd0,
        CAUSE_BOUND = 2'd1,
        CAUSE_PERM  = 2'd2,
        CAUSE_NONE  = 2'd3
    } cause_e;

    localparam int RIGHTS_W = 3;
    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHT_EX = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 13,
    parameter int PA_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_W-1:0]    wr_seg,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [OFF_W:0]      wr_size,
    input  logic [RIGHTS_W-1:0] wr_rights,
    input  logic [SEG_W-1:0]    lk_seg,
    output logic [PA_W-1:0]     lk_base,
    output logic [OFF_W:0]      lk_size,
    output logic [RIGHTS_W-1:0] lk_rights,
    input  logic [SEG_W-1:0]    rb_seg,
    output logic [PA_W-1:0]     rb_base,
    output logic [OFF_W:0]      rb_size,
    output logic [RIGHTS_W-1:0] rb_rights
);
    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic [PA_W-1:0]     base;
        logic [OFF_W:0]      size;
        logic [RIGHTS_W-1:0] rights;
    } desc_t;

    desc_t tab_d [NSEG];
    desc_t tab_q [NSEG];

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            tab_d[i] = tab_q[i];
        end
        if (wr_en) begin
            tab_d[wr_seg] = '{base: wr_base, size: wr_size, rights: wr_rights};
        end
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab_q[g] <= '0;
            end else begin
                tab_q[g] <= tab_d[g];
            end
        end
    end

    assign lk_base   = tab_q[lk_seg].base;
    assign lk_size   = tab_q[lk_seg].size;
    assign lk_rights = tab_q[lk_seg].rights;
    assign rb_base   = tab_q[rb_seg].base;
    assign rb_size   = tab_q[rb_seg].size;
    assign rb_rights = tab_q[rb_seg].rights;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 13,
    parameter int PA_W  = 24
) (
    input  logic [1:0]          kind,
    input  logic [OFF_W-1:0]    off,
    input  logic [PA_W-1:0]     base,
    input  logic [OFF_W:0]      size,
    input  logic [RIGHTS_W-1:0] rights,
    output cause_e              cause,
    output logic [PA_W-1:0]     paddr
);
    logic need_ok;

    always_comb begin
        unique case (kind_e'(kind))
            KIND_FETCH: need_ok = rights[RIGHT_EX];
            KIND_READ:  need_ok = rights[RIGHT_RD];
            KIND_WRITE: need_ok = rights[RIGHT_WR];
            default:    need_ok = 1'b0;
        endcase

        if (rights == '0) begin
            cause = CAUSE_NONE;
        end else if ({1'b0, off} >= size) begin
            cause = CAUSE_BOUND;
        end else if (!need_ok) begin
            cause = CAUSE_PERM;
        end else begin
            cause = CAUSE_OK;
        end

        paddr = base + PA_W'(off);
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 13,
    parameter int PA_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [SEG_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic                cfg_we,
    input  logic [SEG_W-1:0]    cfg_seg,
    input  logic [PA_W-1:0]     cfg_base,
    input  logic [OFF_W:0]      cfg_size,
    input  logic [2:0]          cfg_rights,
    input  logic [SEG_W-1:0]    cfg_rd_seg,
    output logic [PA_W-1:0]     cfg_rd_base,
    output logic [OFF_W:0]      cfg_rd_size,
    output logic [2:0]          cfg_rd_rights,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic                rsp_fault,
    output logic [1:0]          rsp_cause
);
    typedef struct packed {
        logic            valid;
        logic            fault;
        cause_e          cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [PA_W-1:0]     lk_base;
    logic [OFF_W:0]      lk_size;
    logic [RIGHTS_W-1:0] lk_rights;
    cause_e              chk_cause;
    logic [PA_W-1:0]     chk_paddr;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_seg    (cfg_seg),
        .wr_base   (cfg_base),
        .wr_size   (cfg_size),
        .wr_rights (cfg_rights),
        .lk_seg    (req_seg),
        .lk_base   (lk_base),
        .lk_size   (lk_size),
        .lk_rights (lk_rights),
        .rb_seg    (cfg_rd_seg),
        .rb_base   (cfg_rd_base),
        .rb_size   (cfg_rd_size),
        .rb_rights (cfg_rd_rights)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) i_check (
        .kind   (req_kind),
        .off    (req_off),
        .base   (lk_base),
        .size   (lk_size),
        .rights (lk_rights),
        .cause  (chk_cause),
        .paddr  (chk_paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.cause = chk_cause;
            rsp_d.fault = (chk_cause != CAUSE_OK);
            rsp_d.paddr = (chk_cause == CAUSE_OK) ? chk_paddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/seg_xlate_checks.sv
module seg_xlate_checks #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 13,
    parameter int PA_W  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_kind,
    input logic [SEG_W-1:0] req_seg,
    input logic [OFF_W-1:0] req_off,
    input logic             cfg_we,
    input logic [SEG_W-1:0] cfg_seg,
    input logic [PA_W-1:0]  cfg_base,
    input logic [OFF_W:0]   cfg_size,
    input logic [2:0]       cfg_rights,
    input logic [SEG_W-1:0] cfg_rd_seg,
    input logic [PA_W-1:0]  cfg_rd_base,
    input logic [OFF_W:0]   cfg_rd_size,
    input logic [2:0]       cfg_rd_rights,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rsp_valid == $past(req_valid)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_cause == 2'd0 && rsp_paddr == '0));

    assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0 && rsp_cause != 2'd0));

    assert_rsvd_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(req_valid) && $past(req_kind) == 2'd3) |-> (rsp_fault && rsp_cause != 2'd0));

    assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(cfg_we) && cfg_rd_seg == $past(cfg_seg))
        |-> (cfg_rd_base == $past(cfg_base) && cfg_rd_size == $past(cfg_size)
             && cfg_rd_rights == $past(cfg_rights)));

endmodule

bind seg_xlate_unit seg_xlate_checks #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_checks (.*);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W = 3;
    localparam int OFF_W = 13;
    localparam int PA_W  = 24;
    localparam int NSEG  = 1 << SEG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = '0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic             cfg_we = 1'b0;
    logic [SEG_W-1:0] cfg_seg = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFF_W:0]   cfg_size = '0;
    logic [2:0]       cfg_rights = '0;
    logic [SEG_W-1:0] cfg_rd_seg = '0;
    logic [PA_W-1:0]  cfg_rd_base;
    logic [OFF_W:0]   cfg_rd_size;
    logic [2:0]       cfg_rd_rights;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic             rsp_fault;
    logic [1:0]       rsp_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [PA_W-1:0] m_base   [NSEG];
    logic [OFF_W:0]  m_size   [NSEG];
    logic [2:0]      m_rights [NSEG];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate_unit #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlate_unit (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] kind, input int seg, input logic [OFF_W-1:0] off,
                                  output logic [1:0] cause, output logic [PA_W-1:0] pa);
        logic need;
        case (kind)
            2'd0: need = m_rights[seg][2];
            2'd1: need = m_rights[seg][0];
            2'd2: need = m_rights[seg][1];
            default: need = 1'b0;
        endcase
        if (m_rights[seg] == 3'b000) cause = 2'd3;
        else if ({1'b0, off} >= m_size[seg]) cause = 2'd1;
        else if (!need) cause = 2'd2;
        else cause = 2'd0;
        pa = (cause == 2'd0) ? PA_W'(m_base[seg] + PA_W'(off)) : '0;
    endfunction

    task automatic write_desc(int seg, logic [PA_W-1:0] b, logic [OFF_W:0] s, logic [2:0] r);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = SEG_W'(seg); cfg_base = b; cfg_size = s; cfg_rights = r;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[seg] = b; m_size[seg] = s; m_rights[seg] = r;
    endtask

    task automatic do_req(string req, logic [1:0] kind, int seg, logic [OFF_W-1:0] off);
        logic [1:0] ec;
        logic [PA_W-1:0] ep;
        model(kind, seg, off, ec, ep);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_seg = SEG_W'(seg); req_off = off;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " cause"}, 32'(rsp_cause), 32'(ec));
        check({req, " fault"}, 32'(rsp_fault), 32'(ec != 2'd0));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ep));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_rights[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset contents via read port, R2 idle outputs
        for (int s = 0; s < NSEG; s++) begin
            cfg_rd_seg = SEG_W'(s);
            #1;
            check("R1 reset base", 32'(cfg_rd_base), 32'd0);
            check("R1 reset size", 32'(cfg_rd_size), 32'd0);
            check("R1 reset rights", 32'(cfg_rd_rights), 32'd0);
        end
        check("R2 idle valid", 32'(rsp_valid), 32'd0);
        check("R2 idle fault", 32'(rsp_fault), 32'd0);
        for (int s = 0; s < NSEG; s++) do_req("R1 unloaded", 2'd1, s, 13'd5);

        // R8 load a table
        for (int s = 0; s < NSEG; s++) begin
            logic [OFF_W:0] sz;
            logic [2:0] rt;
            sz = (s == 7) ? 14'd8192 : (s == 1) ? 14'd0 : 14'(s * 1100 + 5);
            rt = (s == 6) ? 3'b000 : 3'(s);
            if (s == 7) rt = 3'b111;
            write_desc(s, PA_W'(24'hFFF000 + s * 24'h1F3A1), sz, rt);
        end
        for (int s = 0; s < NSEG; s++) begin
            cfg_rd_seg = SEG_W'(s);
            #1;
            check("R8 readback base", 32'(cfg_rd_base), 32'(m_base[s]));
            check("R8 readback size", 32'(cfg_rd_size), 32'(m_size[s]));
            check("R8 readback rights", 32'(cfg_rd_rights), 32'(m_rights[s]));
        end

        // R3 R4 R5 R6 R7 sweep over segment, kind and boundary offsets
        for (int s = 0; s < NSEG; s++) begin
            for (int k = 0; k < 4; k++) begin
                for (int j = 0; j < 7; j++) begin
                    int o;
                    case (j)
                        0: o = 0;
                        1: o = 1;
                        2: o = int'(m_size[s]) - 1;
                        3: o = int'(m_size[s]);
                        4: o = int'(m_size[s]) + 1;
                        5: o = 8191;
                        default: o = 4096;
                    endcase
                    do_req("R3/R4/R5/R6/R7 sweep", 2'(k), s, OFF_W'(o));
                end
            end
        end

        // R9 same-cycle write and lookup on segment 2
        begin
            logic [1:0] ec;
            logic [PA_W-1:0] ep;
            model(2'd1, 2, 13'd10, ec, ep);
            @(negedge clk);
            req_valid = 1'b1; req_kind = 2'd1; req_seg = 3'd2; req_off = 13'd10;
            cfg_we = 1'b1; cfg_seg = 3'd2; cfg_base = 24'h123000; cfg_size = 14'd64; cfg_rights = 3'b001;
            @(negedge clk);
            req_valid = 1'b0; cfg_we = 1'b0;
            m_base[2] = 24'h123000; m_size[2] = 14'd64; m_rights[2] = 3'b001;
            check("R9 old cause", 32'(rsp_cause), 32'(ec));
            check("R9 old paddr", 32'(rsp_paddr), 32'(ep));
            do_req("R9 new contents", 2'd1, 2, 13'd10);
        end

        @(negedge clk);
        check("R2 idle after traffic", 32'(rsp_valid), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule